// File: doc/BRIEF.md
# Asynchronous Memory Bus Strobe Generator

This block is the initiating side of an asynchronous, chip-select based external memory bus, of the kind a processor uses to reach a peripheral device such as an FPGA placed in one select space. A request (read or write, address, write data) is accepted on a ready/valid pair. The block then runs one bus access, timed entirely in bus clock cycles. First a setup phase drives chip select and address. Then a strobe phase pulls write enable or output enable low. Then a hold phase keeps chip select, address and write data steady. A turnaround gap follows before the next access may start.

All phase lengths come from a 30-bit configuration word of packed fields. A field holding N produces a phase of N+1 cycles. The word is captured only when a request is accepted, so it may be rewritten at any time and the change applies from the next access on. A size field picks 8-bit or 16-bit data. On the narrow setting the unused upper byte lane is forced to zero on both write and read data. Read data is taken from the bus on the final strobe cycle. It is presented together with a one-cycle completion pulse.

Top module: `xbus_strobe_master`

## Requirements
- R1: While reset is held, chip select, write enable and output enable are high, the data drive enable is low, the completion pulse is low and the request ready is high.
- R2: After a request is accepted, chip select is low and the address is driven for SU+1 cycles with both strobes high. SU is bits 29:26 for a write and bits 16:13 for a read.
- R3: During a write, write enable is low for WS+1 cycles right after setup, with WS in bits 25:20. The data drive enable is high and the write data is on the bus for the whole access.
- R4: After write enable rises, chip select stays low with address and data held for WH+1 cycles, with WH in bits 19:17. Then chip select rises.
- R5: During a read, output enable is low for RS+1 cycles after setup, with RS in bits 12:7. Chip select is then held low for RH+1 further cycles, with RH in bits 6:4.
- R6: Read data is the bus input value sampled at the end of the last output-enable cycle. It is shown on the read data output from the first cycle after chip select rises.
- R7: The completion pulse is high for exactly one cycle per access. That cycle is the first one after chip select rises.
- R8: After each access, chip select stays high for exactly TA+1 cycles before a pending request can start the next access, with TA in bits 3:2. The request ready output is high only in the last of those cycles or when the bus is idle.
- R9: Size code 00 in bits 1:0 selects 8-bit data: the upper byte of the driven write data and of the returned read data is zero. Any other code uses the full 16 bits.
- R10: The configuration word is captured when a request is accepted. Changing it during an access alters neither that access's timing nor its data width.
- R11: Write enable and output enable are never low together. The data drive enable stays low throughout a read and its turnaround gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_word | input | 30 | Packed timing and size configuration |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (20) | Request address |
| req_wdata | input | DW (16) | Write data |
| req_ready | output | 1 | Request is accepted this cycle if valid |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW (16) | Last read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_addr | output | AW (20) | Bus address |
| bus_dout | output | DW (16) | Bus write data |
| bus_doe | output | 1 | Bus data drive enable, active high |
| bus_din | input | DW (16) | Bus read data |

## Verification
The first setup cycle is visible in the cycle right after the accepting edge. Each later phase boundary falls exactly N+1 cycles after the one before it. The completion pulse and the new read data both appear in the first cycle with chip select high. The bench drives inputs and samples outputs on the falling edge. It counts, cycle by cycle, how many cycles each pin spends in each state. It compares those counts with the field values plus one, rather than looking at fixed instants. The bus input is given a new value on every strobe cycle, so the captured read data shows exactly which cycle was sampled.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int SU_W  = 4;
  localparam int ST_W  = 6;
  localparam int HO_W  = 3;
  localparam int TA_W  = 2;
  localparam int SZ_W  = 2;
  localparam int CW    = ST_W;
  localparam int CFG_W = 2 * (SU_W + ST_W + HO_W) + TA_W + SZ_W;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_TURN   = 3'd4
  } phase_e;

  typedef struct packed {
    logic [SU_W-1:0] wsu;
    logic [ST_W-1:0] wst;
    logic [HO_W-1:0] who;
    logic [SU_W-1:0] rsu;
    logic [ST_W-1:0] rst;
    logic [HO_W-1:0] rho;
    logic [TA_W-1:0] ta;
    logic [SZ_W-1:0] sz;
  } tcfg_t;

endpackage

// File: rtl/xbus_rst_sync.sv
module xbus_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/xbus_phase_ctrl.sv
module xbus_phase_ctrl
  import xbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_write,
  input  tcfg_t  cfg_in,
  output phase_e phase,
  output logic   wr_q,
  output logic   narrow,
  output logic   last,
  output logic   accept,
  output logic   done,
  output logic   req_ready
);

  tcfg_t          cfg_q;
  phase_e         phase_n;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  cnt_n;
  logic [CW-1:0]  lim;
  logic           done_n;

  // phase length limit, selected from the captured configuration
  always_comb begin
    lim = '0;
    case (phase)
      PH_SETUP:  lim = wr_q ? {{(CW-SU_W){1'b0}}, cfg_q.wsu} : {{(CW-SU_W){1'b0}}, cfg_q.rsu};
      PH_STROBE: lim = wr_q ? cfg_q.wst : cfg_q.rst;
      PH_HOLD:   lim = wr_q ? {{(CW-HO_W){1'b0}}, cfg_q.who} : {{(CW-HO_W){1'b0}}, cfg_q.rho};
      PH_TURN:   lim = {{(CW-TA_W){1'b0}}, cfg_q.ta};
      default:   lim = '0;
    endcase
  end

  assign last      = (cnt == lim);
  assign req_ready = (phase == PH_IDLE) || ((phase == PH_TURN) && last);
  assign accept    = req_valid && req_ready;
  assign narrow    = (cfg_q.sz == 2'b00);

  // next-state process
  always_comb begin
    phase_n = phase;
    done_n  = 1'b0;
    case (phase)
      PH_IDLE:   if (accept) phase_n = PH_SETUP;
      PH_SETUP:  if (last) phase_n = PH_STROBE;
      PH_STROBE: if (last) phase_n = PH_HOLD;
      PH_HOLD: begin
        if (last) begin
          phase_n = PH_TURN;
          done_n  = 1'b1;
        end
      end
      PH_TURN:   if (last) phase_n = accept ? PH_SETUP : PH_IDLE;
      default:   phase_n = PH_IDLE;
    endcase
    if ((phase_n != phase) || (phase == PH_IDLE) || (phase == PH_TURN && last)) begin
      cnt_n = '0;
    end else begin
      cnt_n = cnt + 1'b1;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
      wr_q  <= 1'b0;
      cfg_q <= '0;
    end else begin
      phase <= phase_n;
      cnt   <= cnt_n;
      done  <= done_n;
      if (accept) begin
        wr_q  <= req_write;
        cfg_q <= cfg_in;
      end
    end
  end

  assert_accept_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (phase == PH_SETUP));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_to_turn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD && last) |=> (phase == PH_TURN && done));

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> (cnt <= lim));

  assert_cfg_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STROBE) |=> $stable(cfg_q));

endmodule

// File: rtl/xbus_pin_drive.sv
module xbus_pin_drive
  import xbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  phase_e        phase,
  input  logic          wr_q,
  input  logic          narrow,
  input  logic          last,
  input  logic [DW-1:0] bus_din,
  output logic          bus_cs_n,
  output logic          bus_we_n,
  output logic          bus_oe_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  output logic [DW-1:0] rd_data
);

  localparam int HW = DW / 2;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rd_q;
  logic [DW-1:0] rd_n;
  logic          active;
  logic          strobe;
  logic          cap_en;

  assign active = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign strobe = (phase == PH_STROBE);
  assign cap_en = strobe && last && !wr_q;

  assign rd_n = narrow ? {{(DW-HW){1'b0}}, bus_din[HW-1:0]} : bus_din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (cap_en) begin
        rd_q <= rd_n;
      end
    end
  end

  assign bus_cs_n = !active;
  assign bus_we_n = !(strobe && wr_q);
  assign bus_oe_n = !(strobe && !wr_q);
  assign bus_doe  = active && wr_q;
  assign bus_addr = addr_q;
  assign bus_dout = narrow ? {{(DW-HW){1'b0}}, wdata_q[HW-1:0]} : wdata_q;
  assign rd_data  = rd_q;

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_we_n && !bus_oe_n));

  assert_read_no_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> !bus_doe);

  assert_we_inside_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> !bus_cs_n);

  assert_narrow_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow && !bus_cs_n && wr_q) |-> (bus_dout[DW-1:HW] == '0));

endmodule

// File: rtl/xbus_strobe_master.sv
module xbus_strobe_master
  import xbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             done,
  output logic [DW-1:0]    rd_data,
  output logic             bus_cs_n,
  output logic             bus_we_n,
  output logic             bus_oe_n,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_dout,
  output logic             bus_doe,
  input  logic [DW-1:0]    bus_din
);

  logic   rst_sync_n;
  tcfg_t  cfg_in;
  phase_e phase;
  logic   wr_q;
  logic   narrow;
  logic   last;
  logic   accept;

  assign cfg_in = tcfg_t'(cfg_word);

  xbus_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xbus_phase_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .cfg_in    (cfg_in),
    .phase     (phase),
    .wr_q      (wr_q),
    .narrow    (narrow),
    .last      (last),
    .accept    (accept),
    .done      (done),
    .req_ready (req_ready)
  );

  xbus_pin_drive #(
    .AW (AW),
    .DW (DW)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .phase     (phase),
    .wr_q      (wr_q),
    .narrow    (narrow),
    .last      (last),
    .bus_din   (bus_din),
    .bus_cs_n  (bus_cs_n),
    .bus_we_n  (bus_we_n),
    .bus_oe_n  (bus_oe_n),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe),
    .rd_data   (rd_data)
  );

endmodule

// File: tb/xbus_strobe_master_test.sv
module xbus_strobe_master_test;

  logic        clk;
  logic        rst_n;
  logic [29:0] cfg_word;
  logic        req_valid;
  logic        req_write;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_ready;
  logic        done;
  logic [15:0] rd_data;
  logic        bus_cs_n;
  logic        bus_we_n;
  logic        bus_oe_n;
  logic [19:0] bus_addr;
  logic [15:0] bus_dout;
  logic        bus_doe;
  logic [15:0] bus_din;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  xbus_strobe_master uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_word  (cfg_word),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .done      (done),
    .rd_data   (rd_data),
    .bus_cs_n  (bus_cs_n),
    .bus_we_n  (bus_we_n),
    .bus_oe_n  (bus_oe_n),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe),
    .bus_din   (bus_din)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [29:0] mk(int wsu, int wst, int who, int rsu,
                                     int rst, int rho, int ta, int sz);
    return {4'(wsu), 6'(wst), 3'(who), 4'(rsu), 6'(rst), 3'(rho), 2'(ta), 2'(sz)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R1: reset state
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(bus_cs_n == 1'b1, "R1", "cs_n in reset", int'(bus_cs_n), 1);
    chk(bus_we_n == 1'b1 && bus_oe_n == 1'b1, "R1", "strobes in reset",
        int'({bus_we_n, bus_oe_n}), 3);
    chk(bus_doe == 1'b0 && done == 1'b0, "R1", "doe/done in reset",
        int'({bus_doe, done}), 0);
    chk(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // one access, measuring every phase; c is the word in force at accept,
  // c_after is applied right after acceptance (R10)
  task automatic t_access(input bit wr, input logic [19:0] a, input logic [15:0] d,
                          input logic [29:0] c, input logic [29:0] c_after);
    int su, st, ho, ta;
    int nsu = 0, nst = 0, nho = 0, nturn = 0, ndone = 0;
    int m = 0;
    bit narrow, first_hi = 1'b1, got_done = 1'b0, fin = 1'b0;
    bit bad_addr = 0, bad_data = 0, bad_doe = 0, bad_excl = 0;
    logic [15:0] rd_seen = '0;
    logic [15:0] exp_w, exp_r;
    string rs, rst_, rh;
    su = wr ? int'(c[29:26]) : int'(c[16:13]);
    st = wr ? int'(c[25:20]) : int'(c[12:7]);
    ho = wr ? int'(c[19:17]) : int'(c[6:4]);
    ta = int'(c[3:2]);
    narrow = (c[1:0] == 2'b00);
    rs   = wr ? "R2" : "R2/R5";
    rst_ = wr ? "R3" : "R5";
    rh   = wr ? "R4" : "R5";
    exp_w = narrow ? {8'h00, d[7:0]} : d;
    exp_r = {a[7:0] ^ 8'h5A, 8'(st)};
    if (narrow) exp_r[15:8] = 8'h00;

    @(negedge clk);
    cfg_word = c; req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_word  = c_after;
    for (int i = 0; i < 400; i++) begin
      if (!bus_cs_n) begin
        if (bus_addr != a) bad_addr = 1;
        if (!bus_we_n && !bus_oe_n) bad_excl = 1;
        if (wr) begin
          if (!bus_doe) bad_doe = 1;
          if (bus_dout != exp_w) bad_data = 1;
          if (!bus_oe_n) bad_excl = 1;
        end else begin
          if (bus_doe) bad_doe = 1;
          if (!bus_we_n) bad_excl = 1;
        end
        if (done) ndone++;
        if (wr ? !bus_we_n : !bus_oe_n) begin
          if (!wr) bus_din = {a[7:0] ^ 8'h5A, 8'(nst)};
          nst++;
          m = 1;
        end else if (m == 0) begin
          nsu++;
        end else begin
          nho++;
        end
      end else begin
        nturn++;
        if (done) ndone++;
        if (first_hi) begin
          got_done = done;
          rd_seen  = rd_data;
          first_hi = 1'b0;
        end
        if (bus_doe) bad_doe = 1;
        if (req_ready) begin
          fin = 1'b1;
          break;
        end
      end
      @(negedge clk);
    end
    bus_din = 16'hFFFF;

    chk(fin, rs, "access finished", int'(fin), 1);
    chk(nsu == su + 1, rs, "setup cycles", nsu, su + 1);
    chk(nst == st + 1, rst_, "strobe cycles", nst, st + 1);
    chk(nho == ho + 1, rh, "hold cycles", nho, ho + 1);
    chk(!bad_addr, rs, "address held", int'(bad_addr), 0);
    chk(ndone == 1 && got_done, "R7", "done pulses", ndone, 1);
    chk(nturn == ta + 1, "R8", "turnaround cycles", nturn, ta + 1);
    chk(!bad_excl, "R11", "strobe exclusion", int'(bad_excl), 0);
    if (wr) begin
      chk(!bad_data, "R3/R9", "write data", int'(bad_data), 0);
      chk(!bad_doe, "R3", "drive enable on write", int'(bad_doe), 0);
    end else begin
      chk(rd_seen == exp_r, "R6/R9", "read data", int'(rd_seen), int'(exp_r));
      chk(!bad_doe, "R11", "drive enable off on read", int'(bad_doe), 0);
    end
  endtask

  // R8: back-to-back writes with request held
  task automatic t_b2b(input logic [29:0] c);
    int ta = int'(c[3:2]);
    int gap = 0;
    bit rdy_first = 1'b0;
    @(negedge clk);
    cfg_word = c; req_write = 1'b1; req_addr = 20'h00321; req_wdata = 16'h1234;
    req_valid = 1'b1;
    for (int i = 0; i < 200 && bus_cs_n; i++) @(negedge clk);
    for (int i = 0; i < 200 && !bus_cs_n; i++) @(negedge clk);
    rdy_first = req_ready;
    for (int i = 0; i < 200 && bus_cs_n; i++) begin
      gap++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(gap == ta + 1, "R8", "gap between accesses", gap, ta + 1);
    chk(rdy_first == (ta == 0), "R8", "ready in first gap cycle",
        int'(rdy_first), int'(ta == 0));
    for (int i = 0; i < 200 && !req_ready; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cfg_word = '0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; bus_din = 16'hFFFF;
    t_reset();
    // 16-bit write and read, distinct phase lengths (R2 R3 R4 R5 R6 R7 R8)
    t_access(1'b1, 20'h0A5C3, 16'hBEEF, mk(2, 3, 1, 1, 4, 2, 1, 1), mk(2, 3, 1, 1, 4, 2, 1, 1));
    t_access(1'b0, 20'h01234, 16'h0000, mk(2, 3, 1, 1, 4, 2, 2, 1), mk(2, 3, 1, 1, 4, 2, 2, 1));
    // minimum lengths
    t_access(1'b1, 20'hFFFFF, 16'h5AA5, mk(0, 0, 0, 0, 0, 0, 0, 1), mk(0, 0, 0, 0, 0, 0, 0, 1));
    t_access(1'b0, 20'h00077, 16'h0000, mk(0, 0, 0, 0, 0, 0, 0, 1), mk(0, 0, 0, 0, 0, 0, 0, 1));
    // maximum lengths
    t_access(1'b1, 20'h40000, 16'hC001, mk(15, 63, 7, 15, 63, 7, 3, 1), mk(15, 63, 7, 15, 63, 7, 3, 1));
    t_access(1'b0, 20'h00F0F, 16'h0000, mk(15, 63, 7, 15, 63, 7, 3, 3), mk(15, 63, 7, 15, 63, 7, 3, 3));
    // R9: 8-bit size
    t_access(1'b1, 20'h12345, 16'hABCD, mk(1, 2, 1, 1, 2, 1, 0, 0), mk(1, 2, 1, 1, 2, 1, 0, 0));
    t_access(1'b0, 20'h000E1, 16'h0000, mk(1, 2, 1, 3, 5, 1, 1, 0), mk(1, 2, 1, 3, 5, 1, 1, 0));
    // R10: configuration rewritten during an access
    t_access(1'b1, 20'h00100, 16'h9876, mk(1, 2, 1, 1, 2, 1, 1, 1), mk(9, 40, 6, 9, 40, 6, 3, 0));
    t_access(1'b0, 20'h00200, 16'h0000, mk(3, 5, 2, 2, 6, 3, 2, 0), mk(0, 1, 0, 0, 1, 0, 0, 1));
    // R8: back-to-back with request held
    t_b2b(mk(1, 1, 1, 1, 1, 1, 3, 1));
    t_b2b(mk(0, 2, 0, 0, 2, 0, 0, 1));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule